// File: doc/BRIEF.md
# Downstream Port Command Register and Traffic Gate

This block keeps the 16-bit command register of a bridge-style downstream port and uses its control bits to decide the fate of traffic crossing the port. Configuration software reads and writes the register through a simple dword-addressed port with per-byte enables. The register fills the low half of one dword and resets to zero. Three enable bits steer traffic. One decides whether cycles started by the device below may travel upstream. The other two decide whether memory and I/O cycles that fall inside the programmed address windows may travel downstream. A cycle that is refused is reported as a master abort.

A fourth bit gates the legacy interrupt messages that the port itself raises for pending hot-plug and power-management events. The internal request is level-style. The block sends an assert message when the gated request becomes active and a deassert message when it goes away. Interrupt messages that arrive from devices below the port are passed on to the interrupt controller whatever that bit says. The window base and limit values are plain inputs.

Top module: `port_cmd_gate`

## Requirements
- R1: After reset the command register reads 0000h. It is visible in bits 15:0 of dword index 1 (byte offset 04h). Bits 31:16 of that dword read 0, and every other dword index reads 0.
- R2: Bits 15:11, bit 9 and bits 7:3 always read 0 and ignore writes. Bit 8, the system-error reporting enable, is fixed at 0 even when software writes 1.
- R3: A write with cfg_be[0]=1 updates bits 7:0, and one with cfg_be[1]=1 updates bits 15:8. A byte whose enable is 0 keeps its value, so a write with only cfg_be[1] set leaves bits 2:0 unchanged.
- R4: A request with req_dir=0 comes from the device below and goes upstream. It is forwarded when bit 2 (bus master enable) is 1 and master-aborted when that bit is 0. Every verdict shows on rsp_valid/rsp_fwd/rsp_abort exactly one clock after the request.
- R5: A request with req_dir=1 and req_io=0 is a downstream memory cycle. If its address lies in the window mem_base ≤ addr ≤ mem_limit (both ends included), it is forwarded when bit 1 (memory space enable) is 1 and aborted when that bit is 0.
- R6: A request with req_dir=1 and req_io=1 is a downstream I/O cycle. If its address lies in the window io_base ≤ addr ≤ io_limit (both ends included), it is forwarded when bit 0 (I/O space enable) is 1 and aborted when that bit is 0.
- R7: A downstream request whose address lies outside its window is not claimed. The port gives rsp_valid=1 with rsp_fwd=0 and rsp_abort=0, whatever the enable bits hold.
- R8: With bit 10 (interrupt disable) at 0, a rise of hp_evt or pm_evt produces a one-cycle own_assert pulse one clock later. When both events have cleared, a one-cycle own_deassert pulse follows one clock later.
- R9: With bit 10 at 1, pending events produce no own_assert. If bit 10 is cleared while an event is pending, own_assert pulses one clock after the register changes. If bit 10 is set while the own interrupt is asserted, own_deassert pulses one clock after the register changes.
- R10: dn_assert_in and dn_deassert_in appear on up_assert_out and up_deassert_out one clock later whatever bit 10 holds. They can coincide with own_assert or own_deassert.
- R11: A request in the same clock as a config write is judged by the command value in force before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Config write strobe |
| cfg_addr | input | CFG_AW | Config dword index |
| cfg_be | input | 4 | Config byte enables |
| cfg_wdata | input | 32 | Config write data |
| cfg_rdata | output | 32 | Config read data for cfg_addr (combinational) |
| req_valid | input | 1 | Cycle request present |
| req_dir | input | 1 | 0 = from the device going upstream, 1 = going downstream |
| req_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| req_addr | input | AW | Cycle address |
| mem_base | input | AW | Memory window lower bound |
| mem_limit | input | AW | Memory window upper bound |
| io_base | input | AW | I/O window lower bound |
| io_limit | input | AW | I/O window upper bound |
| rsp_valid | output | 1 | Verdict present (one clock after the request) |
| rsp_fwd | output | 1 | Cycle forwarded |
| rsp_abort | output | 1 | Cycle master-aborted |
| hp_evt | input | 1 | Hot-plug interrupt pending (level) |
| pm_evt | input | 1 | Power-management interrupt pending (level) |
| own_assert | output | 1 | Port's own assert message pulse |
| own_deassert | output | 1 | Port's own deassert message pulse |
| dn_assert_in | input | 1 | Assert message received from below |
| dn_deassert_in | input | 1 | Deassert message received from below |
| up_assert_out | output | 1 | Assert message passed to the interrupt controller |
| up_deassert_out | output | 1 | Deassert message passed to the interrupt controller |

## Verification
Two pairs of events can land in the same cycle. First, a config write that flips bus master enable can arrive in the same clock as an upstream request. The bench drives both on one falling edge and expects a verdict made from the old register value, then the new value on the next request. Second, a message from below can arrive in the same cycle as an event that makes the port raise its own interrupt. The bench raises dn_assert_in and hp_evt together and expects own_assert and up_assert_out high in the same cycle, and it repeats this with interrupt disable set to show that only the forwarded message passes.

// File: rtl/port_cmd_pkg.sv
`timescale 1ns/1ps
package port_cmd_pkg;
    localparam int CMD_W    = 16;
    localparam int BIT_IOSE = 0;
    localparam int BIT_MSE  = 1;
    localparam int BIT_BME  = 2;
    localparam int BIT_IDIS = 10;
    localparam logic [CMD_W-1:0] CMD_WMASK =
        CMD_W'((1 << BIT_IDIS) | (1 << BIT_BME) | (1 << BIT_MSE) | (1 << BIT_IOSE));

    typedef struct packed {
        logic idis;
        logic bme;
        logic mse;
        logic iose;
    } cmd_ctl_t;

    typedef enum logic [1:0] {
        VERDICT_NONE  = 2'b00,
        VERDICT_FWD   = 2'b01,
        VERDICT_ABORT = 2'b10
    } verdict_e;

    function automatic logic [CMD_W-1:0] merge_cmd(
        input logic [CMD_W-1:0] old_v,
        input logic [CMD_W-1:0] new_v,
        input logic [1:0]       be
    );
        logic [CMD_W-1:0] res;
        for (int i = 0; i < 2; i++) begin
            res[i*8 +: 8] = be[i] ? (new_v[i*8 +: 8] & CMD_WMASK[i*8 +: 8]) : old_v[i*8 +: 8];
        end
        return res;
    endfunction
endpackage

// File: rtl/cmd_store.sv
`timescale 1ns/1ps
module cmd_store
    import port_cmd_pkg::*;
#(
    parameter int CFG_AW  = 10,
    parameter int CMD_IDX = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [CMD_W-1:0]  cmd_q,
    output cmd_ctl_t          ctl
);
    localparam logic [CFG_AW-1:0] HIT_IDX = CFG_AW'(CMD_IDX);

    logic sel;
    assign sel = cfg_wr && (cfg_addr == HIT_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (sel) begin
            cmd_q <= merge_cmd(cmd_q, cfg_wdata[CMD_W-1:0], cfg_be[1:0]);
        end
    end

    always_comb begin
        ctl.idis = cmd_q[BIT_IDIS];
        ctl.bme  = cmd_q[BIT_BME];
        ctl.mse  = cmd_q[BIT_MSE];
        ctl.iose = cmd_q[BIT_IOSE];
    end

    // R2: reserved and fixed bits never hold a one
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (cmd_q & ~CMD_WMASK) == '0);
    // R3: a write with no low-byte enable leaves bits 7:0 alone
    a_r3_low_byte_kept: assert property (@(posedge clk) disable iff (rst)
        (sel && !cfg_be[0]) |=> $stable(cmd_q[7:0]));
endmodule

// File: rtl/cycle_filter.sv
`timescale 1ns/1ps
module cycle_filter
    import port_cmd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  cmd_ctl_t      ctl,
    input  logic          req_valid,
    input  logic          req_dir,
    input  logic          req_io,
    input  logic [AW-1:0] req_addr,
    input  logic [AW-1:0] mem_base,
    input  logic [AW-1:0] mem_limit,
    input  logic [AW-1:0] io_base,
    input  logic [AW-1:0] io_limit,
    output logic          rsp_valid,
    output logic          rsp_fwd,
    output logic          rsp_abort
);
    localparam int NWIN = 2;   // window 0 = memory, 1 = I/O

    logic [AW-1:0] win_lo [NWIN];
    logic [AW-1:0] win_hi [NWIN];
    logic [NWIN-1:0] win_hit;
    logic [NWIN-1:0] win_en;

    assign win_lo[0] = mem_base;
    assign win_hi[0] = mem_limit;
    assign win_lo[1] = io_base;
    assign win_hi[1] = io_limit;
    assign win_en    = {ctl.iose, ctl.mse};

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        assign win_hit[w] = (req_addr >= win_lo[w]) && (req_addr <= win_hi[w]);
    end

    verdict_e verdict_d;
    verdict_e verdict_q;
    logic     valid_q;

    always_comb begin
        verdict_d = VERDICT_NONE;
        if (!req_dir) begin
            verdict_d = ctl.bme ? VERDICT_FWD : VERDICT_ABORT;
        end else if (win_hit[req_io]) begin
            verdict_d = win_en[req_io] ? VERDICT_FWD : VERDICT_ABORT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q   <= 1'b0;
            verdict_q <= VERDICT_NONE;
        end else begin
            valid_q   <= req_valid;
            verdict_q <= req_valid ? verdict_d : VERDICT_NONE;
        end
    end

    assign rsp_valid = valid_q;
    assign rsp_fwd   = (verdict_q == VERDICT_FWD);
    assign rsp_abort = (verdict_q == VERDICT_ABORT);

    // R4: a verdict appears exactly one clock after a request
    a_r4_one_clock: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    // R4: never both forwarded and aborted
    a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rsp_fwd && rsp_abort));
    // R7: a downstream miss is never claimed
    a_r7_miss_unclaimed: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_dir && !win_hit[req_io]) |=> (!rsp_fwd && !rsp_abort));
    // R4: an upstream cycle with mastering off is aborted
    a_r4_up_abort: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_dir && !ctl.bme) |=> rsp_abort);
endmodule

// File: rtl/intx_gate.sv
`timescale 1ns/1ps
module intx_gate (
    input  logic clk,
    input  logic rst,
    input  logic idis,
    input  logic hp_evt,
    input  logic pm_evt,
    output logic own_assert,
    output logic own_deassert
);
    logic want;
    logic active_q;

    assign want = (hp_evt || pm_evt) && !idis;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q     <= 1'b0;
            own_assert   <= 1'b0;
            own_deassert <= 1'b0;
        end else begin
            active_q     <= want;
            own_assert   <= want && !active_q;
            own_deassert <= !want && active_q;
        end
    end

    // R9: setting the disable bit while active yields a deassert
    a_r9_disable_drops: assert property (@(posedge clk) disable iff (rst)
        (active_q && idis) |=> own_deassert);
    // R8: assert and deassert never coincide
    a_r8_not_both: assert property (@(posedge clk) disable iff (rst)
        !(own_assert && own_deassert));
    // R9: with the disable bit held, no assert is produced
    a_r9_no_assert: assert property (@(posedge clk) disable iff (rst)
        (idis && !active_q) |=> !own_assert);
endmodule

// File: rtl/port_cmd_gate.sv
`timescale 1ns/1ps
module port_cmd_gate
    import port_cmd_pkg::*;
#(
    parameter int CFG_AW  = 10,
    parameter int CMD_IDX = 1,
    parameter int AW      = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              req_valid,
    input  logic              req_dir,
    input  logic              req_io,
    input  logic [AW-1:0]     req_addr,
    input  logic [AW-1:0]     mem_base,
    input  logic [AW-1:0]     mem_limit,
    input  logic [AW-1:0]     io_base,
    input  logic [AW-1:0]     io_limit,
    output logic              rsp_valid,
    output logic              rsp_fwd,
    output logic              rsp_abort,
    input  logic              hp_evt,
    input  logic              pm_evt,
    output logic              own_assert,
    output logic              own_deassert,
    input  logic              dn_assert_in,
    input  logic              dn_deassert_in,
    output logic              up_assert_out,
    output logic              up_deassert_out
);
    localparam logic [CFG_AW-1:0] RD_IDX = CFG_AW'(CMD_IDX);

    logic [CMD_W-1:0] cmd_q;
    cmd_ctl_t         ctl;

    cmd_store #(.CFG_AW(CFG_AW), .CMD_IDX(CMD_IDX)) u_store (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cmd_q(cmd_q), .ctl(ctl)
    );

    cycle_filter #(.AW(AW)) u_filter (
        .clk(clk), .rst(rst), .ctl(ctl),
        .req_valid(req_valid), .req_dir(req_dir), .req_io(req_io), .req_addr(req_addr),
        .mem_base(mem_base), .mem_limit(mem_limit), .io_base(io_base), .io_limit(io_limit),
        .rsp_valid(rsp_valid), .rsp_fwd(rsp_fwd), .rsp_abort(rsp_abort)
    );

    intx_gate u_intx (
        .clk(clk), .rst(rst), .idis(ctl.idis), .hp_evt(hp_evt), .pm_evt(pm_evt),
        .own_assert(own_assert), .own_deassert(own_deassert)
    );

    assign cfg_rdata = (cfg_addr == RD_IDX) ? {16'h0000, cmd_q} : 32'h0;

    always_ff @(posedge clk) begin
        if (rst) begin
            up_assert_out   <= 1'b0;
            up_deassert_out <= 1'b0;
        end else begin
            up_assert_out   <= dn_assert_in;
            up_deassert_out <= dn_deassert_in;
        end
    end

    // R10: messages from below pass regardless of interrupt disable
    a_r10_assert_pass: assert property (@(posedge clk) disable iff (rst)
        dn_assert_in |=> up_assert_out);
    a_r10_deassert_pass: assert property (@(posedge clk) disable iff (rst)
        dn_deassert_in |=> up_deassert_out);
endmodule

// File: tb/port_cmd_gate_bench.sv
`timescale 1ns/1ps
module port_cmd_gate_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [9:0]  cfg_addr;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        req_valid, req_dir, req_io;
    logic [31:0] req_addr;
    logic [31:0] mem_base, mem_limit, io_base, io_limit;
    logic        rsp_valid, rsp_fwd, rsp_abort;
    logic        hp_evt, pm_evt, own_assert, own_deassert;
    logic        dn_assert_in, dn_deassert_in, up_assert_out, up_deassert_out;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    port_cmd_gate u_port_cmd_gate (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_dir(req_dir), .req_io(req_io), .req_addr(req_addr),
        .mem_base(mem_base), .mem_limit(mem_limit), .io_base(io_base), .io_limit(io_limit),
        .rsp_valid(rsp_valid), .rsp_fwd(rsp_fwd), .rsp_abort(rsp_abort),
        .hp_evt(hp_evt), .pm_evt(pm_evt), .own_assert(own_assert), .own_deassert(own_deassert),
        .dn_assert_in(dn_assert_in), .dn_deassert_in(dn_deassert_in),
        .up_assert_out(up_assert_out), .up_deassert_out(up_deassert_out)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [9:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = 4'h0; cfg_addr = 10'd1;
    endtask

    // drives a request on a falling edge; returns {valid,fwd,abort} one clock later
    task automatic issue(input logic dir, input logic io, input logic [31:0] a,
                         output logic [2:0] res);
        @(negedge clk);
        req_valid = 1'b1; req_dir = dir; req_io = io; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        res = {rsp_valid, rsp_fwd, rsp_abort};
    endtask

    task automatic t_reset();
        cfg_addr = 10'd1;
        #0.1;
        check("R1 reset value", cfg_rdata, 32'h0);
        check("R1 reset no verdict", {31'd0, rsp_valid}, 32'd0);
        check("R1 reset no own message", {30'd0, own_assert, own_deassert}, 32'd0);
    endtask

    task automatic t_reserved();
        cfg_write(10'd1, 4'hF, 32'hFFFF_FFFF);
        #0.1;
        check("R2 reserved and SERR read zero", cfg_rdata, 32'h0000_0407);
        cfg_addr = 10'd0;
        #0.1;
        check("R1 other dword reads zero", cfg_rdata, 32'h0);
        cfg_addr = 10'd2;
        #0.1;
        check("R1 next dword reads zero", cfg_rdata, 32'h0);
        cfg_write(10'd0, 4'h3, 32'h0000_0000);
        #0.1;
        check("R1 write to other dword ignored", cfg_rdata, 32'h0000_0407);
    endtask

    task automatic t_byte_en();
        cfg_write(10'd1, 4'h2, 32'h0000_0000);
        #0.1;
        check("R3 upper byte only keeps 2:0", cfg_rdata, 32'h0000_0007);
        cfg_write(10'd1, 4'h1, 32'h0000_FF02);
        #0.1;
        check("R3 lower byte only keeps bit10", cfg_rdata, 32'h0000_0002);
        cfg_write(10'd1, 4'h0, 32'h0000_FFFF);
        #0.1;
        check("R3 no enables no change", cfg_rdata, 32'h0000_0002);
    endtask

    task automatic t_upstream();
        logic [2:0] r;
        cfg_write(10'd1, 4'h3, 32'h0000_0000);
        issue(1'b0, 1'b0, 32'h1234_0000, r);
        check("R4 bus master off aborts", {29'd0, r}, 32'b101);
        cfg_write(10'd1, 4'h3, 32'h0000_0004);
        issue(1'b0, 1'b1, 32'h0000_0010, r);
        check("R4 bus master on forwards", {29'd0, r}, 32'b110);
        @(negedge clk);
        check("R4 no request no verdict", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_mem();
        logic [2:0] r;
        cfg_write(10'd1, 4'h3, 32'h0000_0000);
        issue(1'b1, 1'b0, 32'h8000_0000, r);
        check("R5 memory base hit disabled aborts", {29'd0, r}, 32'b101);
        cfg_write(10'd1, 4'h3, 32'h0000_0002);
        issue(1'b1, 1'b0, 32'h8000_0000, r);
        check("R5 memory base hit forwards", {29'd0, r}, 32'b110);
        issue(1'b1, 1'b0, 32'h800F_FFFF, r);
        check("R5 memory limit hit forwards", {29'd0, r}, 32'b110);
        issue(1'b1, 1'b1, 32'h0000_1000, r);
        check("R6 io hit with only memory enable aborts", {29'd0, r}, 32'b101);
    endtask

    task automatic t_io();
        logic [2:0] r;
        cfg_write(10'd1, 4'h3, 32'h0000_0001);
        issue(1'b1, 1'b1, 32'h0000_1000, r);
        check("R6 io base hit forwards", {29'd0, r}, 32'b110);
        issue(1'b1, 1'b1, 32'h0000_1FFF, r);
        check("R6 io limit hit forwards", {29'd0, r}, 32'b110);
        issue(1'b1, 1'b0, 32'h8000_0004, r);
        check("R5 memory hit with only io enable aborts", {29'd0, r}, 32'b101);
    endtask

    task automatic t_outside();
        logic [2:0] r;
        cfg_write(10'd1, 4'h3, 32'h0000_0007);
        issue(1'b1, 1'b0, 32'h7FFF_FFFF, r);
        check("R7 below memory window unclaimed", {29'd0, r}, 32'b100);
        issue(1'b1, 1'b0, 32'h8010_0000, r);
        check("R7 above memory window unclaimed", {29'd0, r}, 32'b100);
        issue(1'b1, 1'b1, 32'h0000_0FFF, r);
        check("R7 below io window unclaimed", {29'd0, r}, 32'b100);
        cfg_write(10'd1, 4'h3, 32'h0000_0000);
        issue(1'b1, 1'b1, 32'h0000_2000, r);
        check("R7 above io window disabled unclaimed", {29'd0, r}, 32'b100);
    endtask

    task automatic t_intx();
        cfg_write(10'd1, 4'h3, 32'h0000_0000);
        @(negedge clk); hp_evt = 1'b1;
        @(negedge clk);
        check("R8 hot-plug assert pulse", {31'd0, own_assert}, 32'd1);
        @(negedge clk);
        check("R8 assert lasts one cycle", {31'd0, own_assert}, 32'd0);
        pm_evt = 1'b1; hp_evt = 1'b0;
        @(negedge clk);
        check("R8 no repeat while pending", {30'd0, own_assert, own_deassert}, 32'd0);
        pm_evt = 1'b0;
        @(negedge clk);
        check("R8 deassert after events clear", {31'd0, own_deassert}, 32'd1);
        @(negedge clk);
        check("R8 deassert lasts one cycle", {31'd0, own_deassert}, 32'd0);
        pm_evt = 1'b1;
        @(negedge clk);
        check("R8 power event assert pulse", {31'd0, own_assert}, 32'd1);
        pm_evt = 1'b0;
        @(negedge clk);
        check("R8 power event deassert", {31'd0, own_deassert}, 32'd1);
    endtask

    task automatic t_id_toggle();
        cfg_write(10'd1, 4'h3, 32'h0000_0400);
        hp_evt = 1'b1;
        @(negedge clk);
        check("R9 disabled no assert", {31'd0, own_assert}, 32'd0);
        @(negedge clk);
        check("R9 disabled still no assert", {31'd0, own_assert}, 32'd0);
        cfg_write(10'd1, 4'h3, 32'h0000_0000);
        @(negedge clk);
        check("R9 clearing disable asserts", {31'd0, own_assert}, 32'd1);
        cfg_write(10'd1, 4'h3, 32'h0000_0400);
        @(negedge clk);
        check("R9 setting disable deasserts", {31'd0, own_deassert}, 32'd1);
        hp_evt = 1'b0;
        cfg_write(10'd1, 4'h3, 32'h0000_0000);
        @(negedge clk);
    endtask

    task automatic t_forwarded();
        cfg_write(10'd1, 4'h3, 32'h0000_0000);
        @(negedge clk); dn_assert_in = 1'b1; hp_evt = 1'b1;
        @(negedge clk); dn_assert_in = 1'b0;
        check("R10 forwarded assert alongside own", {30'd0, up_assert_out, own_assert}, 32'b11);
        hp_evt = 1'b0; dn_deassert_in = 1'b1;
        @(negedge clk); dn_deassert_in = 1'b0;
        check("R10 forwarded deassert alongside own", {30'd0, up_deassert_out, own_deassert}, 32'b11);
        cfg_write(10'd1, 4'h3, 32'h0000_0400);
        @(negedge clk); dn_assert_in = 1'b1; pm_evt = 1'b1;
        @(negedge clk); dn_assert_in = 1'b0;
        check("R10 forwarded assert passes while disabled", {30'd0, up_assert_out, own_assert}, 32'b10);
        @(negedge clk);
        check("R10 forwarded assert one cycle", {31'd0, up_assert_out}, 32'd0);
        pm_evt = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_same_cycle();
        logic [2:0] r;
        cfg_write(10'd1, 4'h3, 32'h0000_0000);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 10'd1; cfg_be = 4'h3; cfg_wdata = 32'h0000_0004;
        req_valid = 1'b1; req_dir = 1'b0; req_io = 1'b0; req_addr = 32'h0;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = 4'h0; req_valid = 1'b0;
        check("R11 same-cycle write uses old value", {29'd0, rsp_valid, rsp_fwd, rsp_abort}, 32'b101);
        issue(1'b0, 1'b0, 32'h0, r);
        check("R11 next request uses new value", {29'd0, r}, 32'b110);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_wr = 1'b0; cfg_addr = 10'd1; cfg_be = 4'h0; cfg_wdata = 32'h0;
        req_valid = 1'b0; req_dir = 1'b0; req_io = 1'b0; req_addr = 32'h0;
        mem_base = 32'h8000_0000; mem_limit = 32'h800F_FFFF;
        io_base = 32'h0000_1000; io_limit = 32'h0000_1FFF;
        hp_evt = 1'b0; pm_evt = 1'b0; dn_assert_in = 1'b0; dn_deassert_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_reserved();
        t_byte_en();
        t_upstream();
        t_mem();
        t_io();
        t_outside();
        t_intx();
        t_id_toggle();
        t_forwarded();
        t_same_cycle();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule